// File: doc/BRIEF.md
# Remote DMA Data Port

This block is the host-facing data window into a network controller's packet buffer. Software first loads a ring start page, a ring stop page, a remote byte address and a remote byte count through a small register-write interface. It then streams data through a single access port, one byte, half-word or word per request. Each access moves data between the port and an internal byte-wide buffer RAM at the current remote address. The address then steps forward by the access width and the count steps down by the same amount.

The address folds back into the ring. When a step lands exactly on the stop-page boundary, the address is replaced by the start-page boundary. When the count reaches zero, a completion flag is latched in an interrupt status register. That flag drives an interrupt line through a mask. Only a small low area of the buffer and a packet-memory window are backed by storage. Reads anywhere else return all ones.

Top module: `rdp_data_port`

## Requirements
- R1: A half-word access (size code 1) uses the remote address with bit 0 cleared, and a word access (size code 2) uses it with bits 1:0 cleared. A byte access (size code 0) uses it unchanged.
- R2: Each accepted access sets the remote address to the aligned address plus the access width in bytes (1, 2 or 4). It decreases the remote count by the same width, modulo 2^16.
- R3: When the stepped address equals the stop page shifted left by 8, the remote address is loaded with the start page shifted left by 8 instead.
- R4: An accepted access that brings the remote count to zero sets status bit 6 (transfer complete) in the same clock edge.
- R5: The interrupt output is high when any status bit is set together with its mask bit. A config write to the clear register (select 4) clears each status bit whose data bit is 1. The mask is written with select 5.
- R6: A write access while the remote count is zero is ignored: the buffer, address and count are all unchanged.
- R7: A read access while the remote count is zero still returns data and still steps the pointers, so the count wraps to 0x10000 minus the width.
- R8: Storage is backed only where the aligned address is below 32, or is at least 0x200 and below 0x400. A read elsewhere returns 0xFF, 0xFFFF or 0xFFFFFFFF for byte, half or word. A write elsewhere changes no storage but still steps the pointers.
- R9: Multi-byte data is little-endian: the lowest address maps to bits 7:0 of the port data.
- R10: After reset, the address, count, both pages, status, mask, read data and read-valid are zero and the interrupt is low.
- R11: For a read request, the data appears on acc_rdata with acc_rvalid high in the cycle after the request. acc_rvalid is low after a write.
- R12: Config select codes are 0 start page, 1 stop page, 2 remote address and 3 remote count. Pages use the low 8 bits of the config data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Config register write strobe |
| cfg_sel | input | 3 | Config register select (0 start, 1 stop, 2 address, 3 count, 4 status clear, 5 mask) |
| cfg_wdata | input | 16 | Config write data |
| acc_valid | input | 1 | Host data access request |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_size | input | 2 | Access width code: 0 byte, 1 half, 2 word |
| acc_wdata | input | 32 | Host write data, little-endian lanes |
| acc_rdata | output | 32 | Read data, zero above the access width |
| acc_rvalid | output | 1 | Read data valid, one cycle after a read request |
| cur_addr | output | 16 | Current remote address |
| cur_cnt | output | 16 | Current remote byte count |
| isr_o | output | 8 | Interrupt status register |
| irq | output | 1 | Masked interrupt request |

## Verification
Word streams fill the ring and end at count zero. This exposes the stepping, the completion flag and the masked interrupt. Byte and half reads over the same words separate a correct lane order from a swapped one, and odd start addresses separate aligned from unaligned fetches. A word pair placed against the stop page shows whether the fold returns to the start page. Zero-count writes followed by a read-back, and zero-count reads, show the asymmetry between the two directions. Probes just below 32, in the unbacked gap, and on both sides of the packet window separate in-window data from all-ones fill.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [2:0] {
        CFG_START   = 3'd0,
        CFG_STOP    = 3'd1,
        CFG_ADDR    = 3'd2,
        CFG_COUNT   = 3'd3,
        CFG_ISR_CLR = 3'd4,
        CFG_MASK    = 3'd5
    } cfg_sel_e;

    // number of bytes moved by one access of the given size code
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    size_bytes = 3'd1;
            2'd1:    size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

    // byte lanes touched by one access of the given size code
    function automatic logic [LANES-1:0] lane_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    lane_mask = LANES'(4'b0001);
            2'd1:    lane_mask = LANES'(4'b0011);
            default: lane_mask = {LANES{1'b1}};
        endcase
    endfunction

endpackage

// File: rtl/rdp_buffer.sv
module rdp_buffer
    import rdp_pkg::*;
#(
    parameter int MEM_BYTES = 1024,
    localparam int IDX_W    = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [IDX_W-1:0]  base_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    logic [7:0] mem [MEM_BYTES];

    // little-endian: lane k lives at base + k
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int k = 0; k < LANES; k++) begin
                if (wr_lanes[k]) begin
                    mem[base_idx + IDX_W'(k)] <= wr_data[8*k +: 8];
                end
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_rd_lane
        assign rd_data[8*g +: 8] = mem[base_idx + IDX_W'(g)];
    end

endmodule

// File: rtl/rdp_pointer.sv
module rdp_pointer
    import rdp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8,
    localparam int OFS_W = ADDR_W - PAGE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_size,
    output logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] cnt_q,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              go,
    output logic              done
);

    logic [PAGE_W-1:0] start_q, stop_q;
    logic [ADDR_W-1:0] bump, start_base, stop_base, inc, nxt_addr, nxt_cnt;
    logic              ld_addr, ld_cnt;

    always_comb begin
        bump     = ADDR_W'(size_bytes(acc_size));
        eff_addr = addr_q;
        if (bump == ADDR_W'(2)) begin
            eff_addr[0] = 1'b0;
        end else if (bump == ADDR_W'(4)) begin
            eff_addr[1:0] = 2'b00;
        end
        start_base = {start_q, {OFS_W{1'b0}}};
        stop_base  = {stop_q,  {OFS_W{1'b0}}};
        inc        = eff_addr + bump;
        nxt_addr   = (inc == stop_base) ? start_base : inc;
        nxt_cnt    = cnt_q - bump;
        go         = acc_valid && !(acc_write && (cnt_q == '0));
        done       = go && (nxt_cnt == '0);
        ld_addr    = cfg_we && (cfg_sel == CFG_ADDR);
        ld_cnt     = cfg_we && (cfg_sel == CFG_COUNT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            stop_q  <= '0;
            addr_q  <= '0;
            cnt_q   <= '0;
        end else begin
            if (cfg_we && cfg_sel == CFG_START) start_q <= cfg_wdata[PAGE_W-1:0];
            if (cfg_we && cfg_sel == CFG_STOP)  stop_q  <= cfg_wdata[PAGE_W-1:0];
            if (ld_addr)  addr_q <= cfg_wdata;
            else if (go)  addr_q <= nxt_addr;
            if (ld_cnt)   cnt_q  <= cfg_wdata;
            else if (go)  cnt_q  <= nxt_cnt;
        end
    end

    AST_STEP_COUNT: assert property (@(posedge clk) disable iff (rst)
        (go && !cfg_we) |=> (cnt_q == $past(cnt_q) - $past(bump))) else $error("count step"); // R2
    AST_RING_FOLD: assert property (@(posedge clk) disable iff (rst)
        (go && !cfg_we && start_q != stop_q) |=> (addr_q != $past(stop_base))) else $error("ring fold"); // R3
    AST_ZERO_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && cnt_q == '0 && !cfg_we) |=> ($stable(addr_q) && $stable(cnt_q))) else $error("zero write"); // R6
    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (go && !cfg_we && acc_size == SZ_WORD) |=> (addr_q[1:0] == 2'b00)) else $error("word align"); // R1

endmodule

// File: rtl/rdp_irq.sv
module rdp_irq #(
    parameter int ISR_W    = 8,
    parameter int DONE_BIT = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_done,
    input  logic             clr_we,
    input  logic [ISR_W-1:0] clr_bits,
    input  logic             mask_we,
    input  logic [ISR_W-1:0] mask_bits,
    output logic [ISR_W-1:0] isr_q,
    output logic [ISR_W-1:0] imr_q,
    output logic             irq
);

    logic [ISR_W-1:0] clr_vec, set_vec;

    always_comb begin
        clr_vec = clr_we ? clr_bits : '0;
        set_vec = '0;
        set_vec[DONE_BIT] = set_done;
    end

    // a new completion wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q <= '0;
            imr_q <= '0;
        end else begin
            isr_q <= (isr_q & ~clr_vec) | set_vec;
            if (mask_we) imr_q <= mask_bits;
        end
    end

    assign irq = |(isr_q & imr_q);

    AST_DONE_LATCH: assert property (@(posedge clk) disable iff (rst)
        set_done |=> isr_q[DONE_BIT]) else $error("done latch"); // R4
    AST_W1C_DONE: assert property (@(posedge clk) disable iff (rst)
        (clr_we && clr_bits[DONE_BIT] && !set_done) |=> !isr_q[DONE_BIT]) else $error("w1c"); // R5

endmodule

// File: rtl/rdp_data_port.sv
module rdp_data_port
    import rdp_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PAGE_W     = 8,
    parameter int MEM_BYTES  = 1024,
    parameter int PMEM_START = 512,
    parameter int LOW_LIMIT  = 32,
    parameter int ISR_W      = 8,
    parameter int DONE_BIT   = 6,
    localparam int IDX_W     = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_size,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_rvalid,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] cur_cnt,
    output logic [ISR_W-1:0]  isr_o,
    output logic              irq
);

    logic [ADDR_W-1:0] eff_addr;
    logic              go, done, in_win;
    logic [DATA_W-1:0] raw_rd, shaped;
    logic [LANES-1:0]  lanes;
    logic [ISR_W-1:0]  imr_unused;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    rdp_pointer #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_size(acc_size),
        .addr_q(cur_addr), .cnt_q(cur_cnt), .eff_addr(eff_addr),
        .go(go), .done(done)
    );

    assign lanes  = lane_mask(acc_size);
    assign in_win = (eff_addr < ADDR_W'(LOW_LIMIT)) ||
                    ((eff_addr >= ADDR_W'(PMEM_START)) && (eff_addr < ADDR_W'(MEM_BYTES)));

    rdp_buffer #(.MEM_BYTES(MEM_BYTES)) u_buf (
        .clk(clk),
        .wr_en(go && acc_write && in_win),
        .wr_lanes(lanes),
        .base_idx(eff_addr[IDX_W-1:0]),
        .wr_data(acc_wdata),
        .rd_data(raw_rd)
    );

    rdp_irq #(.ISR_W(ISR_W), .DONE_BIT(DONE_BIT)) u_irq (
        .clk(clk), .rst(rst),
        .set_done(done),
        .clr_we(cfg_we && cfg_sel == CFG_ISR_CLR),
        .clr_bits(cfg_wdata[ISR_W-1:0]),
        .mask_we(cfg_we && cfg_sel == CFG_MASK),
        .mask_bits(cfg_wdata[ISR_W-1:0]),
        .isr_q(isr_o), .imr_q(imr_unused), .irq(irq)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_shape
        assign shaped[8*g +: 8] = !lanes[g] ? 8'h00 :
                                  (in_win ? raw_rd[8*g +: 8] : 8'hFF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= acc_valid && !acc_write;
            if (acc_valid && !acc_write) rdata_q <= shaped;
        end
    end

    assign acc_rdata  = rdata_q;
    assign acc_rvalid = rvalid_q;

    AST_READ_RESP: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write) |=> acc_rvalid) else $error("read resp"); // R11
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst)
        acc_rvalid |-> $past(acc_valid && !acc_write)) else $error("stray valid"); // R11

endmodule

// File: tb/rdp_data_port_test.sv
module rdp_data_port_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_rvalid;
    logic [15:0] cur_addr, cur_cnt;
    logic [7:0]  isr_o;
    logic        irq;

    rdp_data_port uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid), .cur_addr(cur_addr), .cur_cnt(cur_cnt),
        .isr_o(isr_o), .irq(irq)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [7:0]  mm [1024];
    logic [15:0] m_addr = '0, m_cnt = '0;
    logic [7:0]  m_start = '0, m_stop = '0, m_isr = '0, m_imr = '0;
    logic [31:0] expq [$];
    string       tagq [$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: pops one expected item per read response
    always @(negedge clk) begin
        if (!rst && acc_rvalid) begin
            if (expq.size() == 0) begin
                total++; bad++;
                $display("FAIL R11 unexpected response act=%h exp=none", acc_rdata);
            end else begin
                chk(tagq.pop_front(), acc_rdata, expq.pop_front());
            end
        end
    end

    task automatic cfg(input logic [2:0] sel, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        case (sel)
            3'd0: m_start = data[7:0];
            3'd1: m_stop  = data[7:0];
            3'd2: m_addr  = data;
            3'd3: m_cnt   = data;
            3'd4: m_isr   = m_isr & ~data[7:0];
            default: m_imr = data[7:0];
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic step(input logic [15:0] a, input int n);
        logic [15:0] a2;
        a2 = a + 16'(n);
        if (a2 == {m_stop, 8'h00}) a2 = {m_start, 8'h00};
        m_addr = a2;
        m_cnt  = m_cnt - 16'(n);
        if (m_cnt == 16'h0) m_isr[6] = 1'b1;
    endtask

    task automatic access(input bit w, input logic [1:0] sz, input logic [31:0] wd, input string tag);
        int n;
        logic [15:0] a;
        bit win;
        logic [31:0] exp;
        n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        a = m_addr;
        if (sz == 2'd1) a[0] = 1'b0;
        if (sz == 2'd2) a[1:0] = 2'b00;
        win = (a < 16'd32) || (a >= 16'h200 && a < 16'h400);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_size = sz; acc_wdata = wd;
        if (w) begin
            if (m_cnt != 16'h0) begin
                if (win) for (int k = 0; k < n; k++) mm[int'(a) + k] = wd[8*k +: 8];
                step(a, n);
            end
        end else begin
            exp = '0;
            for (int k = 0; k < n; k++) exp[8*k +: 8] = win ? mm[int'(a) + k] : 8'hFF;
            expq.push_back(exp);
            tagq.push_back(tag);
            step(a, n);
        end
        @(negedge clk);
        acc_valid = 1'b0;
        chk({tag, " addr"}, 32'(cur_addr), 32'(m_addr));
        chk({tag, " cnt"}, 32'(cur_cnt), 32'(m_cnt));
        chk({tag, " isr"}, 32'(isr_o), 32'(m_isr));
        chk({tag, " irq"}, 32'(irq), 32'(|(m_isr & m_imr)));
        chk("R11 valid", 32'(acc_rvalid), w ? 32'd0 : 32'd1);
    endtask

    initial begin
        #(4 * 150000);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=done");
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 rdata", acc_rdata, 32'h0);
        chk("R10 rvalid", 32'(acc_rvalid), 32'h0);
        chk("R10 addr", 32'(cur_addr), 32'h0);
        chk("R10 cnt", 32'(cur_cnt), 32'h0);
        chk("R10 isr", 32'(isr_o), 32'h0);
        chk("R10 irq", 32'(irq), 32'h0);

        // R12 ring setup
        cfg(3'd0, 16'h0002);
        cfg(3'd1, 16'h0004);
        cfg(3'd5, 16'h0040);
        cfg(3'd2, 16'h0200);
        cfg(3'd3, 16'd16);
        chk("R12 addr load", 32'(cur_addr), 32'h200);
        chk("R12 cnt load", 32'(cur_cnt), 32'd16);

        // R2 word stream, last one completes: R4 and R5
        access(1'b1, 2'd2, 32'h11223344, "R2");
        access(1'b1, 2'd2, 32'h55667788, "R2");
        access(1'b1, 2'd2, 32'h99AABBCC, "R2");
        access(1'b1, 2'd2, 32'hDDEEFF00, "R4");

        // R6 zero-count write ignored, checked by read-back
        cfg(3'd2, 16'h0200);
        access(1'b1, 2'd2, 32'hCAFEBABE, "R6");
        cfg(3'd3, 16'd16);
        access(1'b0, 2'd2, 32'h0, "R6 readback");

        // R9 byte and half order
        access(1'b0, 2'd0, 32'h0, "R9");
        access(1'b0, 2'd0, 32'h0, "R9");
        access(1'b0, 2'd1, 32'h0, "R9");
        // R1 alignment from odd addresses
        cfg(3'd2, 16'h020B);
        access(1'b0, 2'd1, 32'h0, "R1");
        cfg(3'd2, 16'h020E);
        access(1'b0, 2'd2, 32'h0, "R1");

        // R3 wrap at stop page
        cfg(3'd2, 16'h03F8);
        cfg(3'd3, 16'd8);
        access(1'b1, 2'd2, 32'h01020304, "R3");
        access(1'b1, 2'd2, 32'h05060708, "R3");
        cfg(3'd2, 16'h03F8);
        cfg(3'd3, 16'd12);
        access(1'b0, 2'd2, 32'h0, "R3");
        access(1'b0, 2'd2, 32'h0, "R3");
        access(1'b0, 2'd2, 32'h0, "R3");

        // R5 clear by writing one
        cfg(3'd4, 16'h0040);
        chk("R5 isr cleared", 32'(isr_o), 32'h0);
        chk("R5 irq low", 32'(irq), 32'h0);

        // R8 unbacked gap and window edges
        cfg(3'd2, 16'h0100);
        cfg(3'd3, 16'd32);
        access(1'b0, 2'd0, 32'h0, "R8");
        access(1'b0, 2'd1, 32'h0, "R8");
        access(1'b0, 2'd2, 32'h0, "R8");
        access(1'b1, 2'd2, 32'h12345678, "R8");
        cfg(3'd2, 16'h01FC);
        access(1'b0, 2'd2, 32'h0, "R8");
        access(1'b0, 2'd2, 32'h0, "R8");
        cfg(3'd2, 16'h001C);
        access(1'b1, 2'd2, 32'hA5A55A5A, "R8");
        access(1'b0, 2'd2, 32'h0, "R8");
        cfg(3'd2, 16'h001C);
        access(1'b0, 2'd2, 32'h0, "R8");
        cfg(3'd2, 16'h03FC);
        cfg(3'd1, 16'h0000);
        access(1'b0, 2'd2, 32'h0, "R8");
        access(1'b0, 2'd0, 32'h0, "R8");
        cfg(3'd1, 16'h0004);

        // R7 zero-count read still advances
        cfg(3'd4, 16'h00FF);
        cfg(3'd5, 16'h0000);
        cfg(3'd2, 16'h0200);
        cfg(3'd3, 16'h0000);
        access(1'b0, 2'd2, 32'h0, "R7");

        // R5 masked completion, then unmask
        cfg(3'd3, 16'd1);
        access(1'b0, 2'd0, 32'h0, "R5");
        cfg(3'd5, 16'h0040);
        chk("R5 irq unmasked", 32'(irq), 32'h1);

        repeat (4) @(negedge clk);
        chk("R11 queue drained", 32'(expq.size()), 32'h0);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end

endmodule